// File: doc/BRIEF.md
# Voice Envelope Generator

This block shapes the loudness of one synthesizer voice. Software writes three settings: a gate bit, an attack/decay byte and a sustain/release byte. From these the block produces an 8-bit envelope level on every clock. The level climbs linearly to full scale while the gate is held. It then falls toward a programmable sustain level, and once the gate drops it falls to silence.

Steps are paced by a free-running 16-bit rate counter. The counter is compared against a period chosen from a fixed sixteen-entry table. The table index is the 4-bit rate that belongs to the active phase. While falling, a second divider stretches the time between steps as the level shrinks, which gives a piecewise-exponential curve. Once the level reaches zero on the way down, it is frozen there until the next gate rise.

The phases form a three-state machine:
- PH_RELEASE is the reset state.
- RELEASE to ATTACK happens on a gate rise.
- ATTACK to DECAY happens when the level reaches 0xFF.
- ATTACK or DECAY to RELEASE happens on a gate fall.

A register write in the same cycle takes priority over the automatic ATTACK to DECAY move.

Top module: `voice_envelope`

## Requirements
- R1: After reset the level is 0x00, the phase is release with rate 0, all settings and the gate are cleared, and the zero freeze is set, so the level stays 0 while the gate stays low.
- R2: The period for rate settings 0 to 15 is 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251 clocks. The rate counter counts every clock and returns to 0 when it reaches the period. The level can only change on a clock where that happens.
- R3: Gate edges never clear the rate counter. If the gate falls and rises again inside one period, the next attack step still comes one period after the previous step.
- R4: In attack every rate-counter match raises the level by exactly 1. On reaching 0xFF the phase becomes decay.
- R5: In decay the level falls by 1 per paced step and stops at the sustain byte, which is the 4-bit sustain value n repeated in both nibbles (n*0x11).
- R6: In decay and release a step fires only after 1, 2, 4, 8, 16 or 30 rate-counter matches. That divider is reloaded when a step lands on level 0xFF (1), 0x5D (2), 0x36 (4), 0x1A (8), 0x0E (16), 0x06 (30) or 0x00 (1). In attack the divider is bypassed.
- R7: Writing control with gate 1 while the stored gate is 0 enters attack and clears the zero freeze. Writing gate 0 while the stored gate is 1 enters release.
- R8: In the attack/decay byte, bits 7:4 hold the attack rate and bits 3:0 the decay rate. In the sustain/release byte, bits 7:4 hold the sustain value and bits 3:0 the release rate. The gate is bit 0 of the control byte.
- R9: A write of a rate that belongs to the current phase changes the period used on the very next clock.
- R10: A step that lands on 0 in decay or release sets the zero freeze. While it is set the level does not change, whatever rates are written, until a gate rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one envelope cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_gate | input | 1 | Bit 0 of the control byte (gate); the other bits are decoded elsewhere |
| ad_we | input | 1 | Write strobe for the attack/decay byte |
| ad_data | input | 8 | Attack rate in bits 7:4, decay rate in bits 3:0 |
| sr_we | input | 1 | Write strobe for the sustain/release byte |
| sr_data | input | 8 | Sustain value in bits 7:4, release rate in bits 3:0 |
| level | output | 8 | Current envelope level |

## Verification
The assertions assume a write strobe is a single-cycle pulse with settled data, and that reset is held for at least one clock. The properties on level steps also assume the rate counter is never restarted other than through reset. The stimulus writes only at falling clock edges and holds each strobe for exactly one cycle. Random rates are mostly drawn from the fastest few settings so that many phase changes fit in a run. A reference model in the bench follows the same inputs cycle by cycle.

// File: rtl/voice_env_pkg.sv
package voice_env_pkg;

    typedef enum logic [1:0] {
        PH_ATTACK  = 2'd0,
        PH_DECAY   = 2'd1,
        PH_RELEASE = 2'd2
    } env_phase_e;

    localparam int LEVEL_W  = 8;
    localparam int RATE_W   = 16;
    localparam int EXPDIV_W = 5;
    localparam int SET_W    = 4;

    // Rate setting to counter period in clocks.
    function automatic logic [RATE_W-1:0] period_lookup(input logic [SET_W-1:0] sel);
        logic [RATE_W-1:0] p;
        case (sel)
            4'd0:    p = 16'd9;
            4'd1:    p = 16'd32;
            4'd2:    p = 16'd63;
            4'd3:    p = 16'd95;
            4'd4:    p = 16'd149;
            4'd5:    p = 16'd220;
            4'd6:    p = 16'd267;
            4'd7:    p = 16'd313;
            4'd8:    p = 16'd392;
            4'd9:    p = 16'd977;
            4'd10:   p = 16'd1954;
            4'd11:   p = 16'd3126;
            4'd12:   p = 16'd3907;
            4'd13:   p = 16'd11720;
            4'd14:   p = 16'd19532;
            default: p = 16'd31251;
        endcase
        return p;
    endfunction

    // The sustain target repeats the setting in both nibbles.
    function automatic logic [LEVEL_W-1:0] sustain_target(input logic [SET_W-1:0] n);
        return {n, n};
    endfunction

    // Divider reload points along the level scale; elsewhere the divider keeps its value.
    function automatic logic [EXPDIV_W-1:0] expdiv_reload(input logic [LEVEL_W-1:0] lvl,
                                                          input logic [EXPDIV_W-1:0] cur);
        logic [EXPDIV_W-1:0] r;
        case (lvl)
            8'hFF:   r = 5'd1;
            8'h5D:   r = 5'd2;
            8'h36:   r = 5'd4;
            8'h1A:   r = 5'd8;
            8'h0E:   r = 5'd16;
            8'h06:   r = 5'd30;
            8'h00:   r = 5'd1;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/env_rate_timer.sv
module env_rate_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    // Wraps through zero when the period is lowered below the running count.
    assign cnt_inc = cnt_q + {{(W-1){1'b0}}, 1'b1};
    assign tick    = (cnt_inc == period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/env_exp_divider.sv
module env_exp_divider
    import voice_env_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                bypass,
    input  logic                step_done,
    input  logic [LEVEL_W-1:0]  new_level,
    output logic                fire,
    output logic [EXPDIV_W-1:0] div_period
);
    logic [EXPDIV_W-1:0] cnt_q;
    logic [EXPDIV_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + {{(EXPDIV_W-1){1'b0}}, 1'b1};
    assign fire    = tick && (bypass || (cnt_inc == div_period));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= fire ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_period <= EXPDIV_W'(1);
        end else if (step_done) begin
            div_period <= expdiv_reload(new_level, div_period);
        end
    end
endmodule

// File: rtl/voice_envelope.sv
module voice_envelope
    import voice_env_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic               ctrl_gate,
    input  logic               ad_we,
    input  logic [7:0]         ad_data,
    input  logic               sr_we,
    input  logic [7:0]         sr_data,
    output logic [LEVEL_W-1:0] level
);
    localparam logic [LEVEL_W-1:0] LVL_FULL = {LEVEL_W{1'b1}};
    localparam logic [LEVEL_W-1:0] LVL_ZERO = '0;

    env_phase_e          phase_q, phase_n;
    logic                gate_q;
    logic [SET_W-1:0]    atk_q, dec_q, sus_q, rel_q;
    logic                hold_q, hold_n;
    logic [LEVEL_W-1:0]  level_q, level_n;
    logic [SET_W-1:0]    rate_sel;
    logic [RATE_W-1:0]   period;
    logic                rate_tick;
    logic                div_fire;
    logic                step;
    logic                reach_full;
    logic                gate_rise, gate_fall;
    logic [EXPDIV_W-1:0] exp_period;

    assign gate_rise = ctrl_we &&  ctrl_gate && !gate_q;
    assign gate_fall = ctrl_we && !ctrl_gate &&  gate_q;

    // Settings registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            atk_q  <= '0;
            dec_q  <= '0;
            sus_q  <= '0;
            rel_q  <= '0;
        end else begin
            if (ctrl_we) gate_q <= ctrl_gate;
            if (ad_we) begin
                atk_q <= ad_data[7:4];
                dec_q <= ad_data[3:0];
            end
            if (sr_we) begin
                sus_q <= sr_data[7:4];
                rel_q <= sr_data[3:0];
            end
        end
    end

    // The active period follows the phase, so a write to the phase's own rate takes effect at once.
    always_comb begin
        unique case (phase_q)
            PH_ATTACK:  rate_sel = atk_q;
            PH_DECAY:   rate_sel = dec_q;
            PH_RELEASE: rate_sel = rel_q;
            default:    rate_sel = rel_q;
        endcase
    end

    assign period = period_lookup(rate_sel);

    env_rate_timer #(.W(RATE_W)) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .tick   (rate_tick)
    );

    env_exp_divider i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (rate_tick),
        .bypass     (phase_q == PH_ATTACK),
        .step_done  (step),
        .new_level  (level_n),
        .fire       (div_fire),
        .div_period (exp_period)
    );

    assign step = div_fire && !hold_q;

    // Next level and the automatic end of attack
    always_comb begin
        level_n    = level_q;
        reach_full = 1'b0;
        if (step) begin
            unique case (phase_q)
                PH_ATTACK: begin
                    level_n    = level_q + 8'd1;
                    reach_full = (level_n == LVL_FULL);
                end
                PH_DECAY: begin
                    if (level_q != sustain_target(sus_q)) level_n = level_q - 8'd1;
                end
                PH_RELEASE: level_n = level_q - 8'd1;
                default:    level_n = level_q;
            endcase
        end
    end

    // Next phase: register writes outrank the automatic transition.
    always_comb begin
        phase_n = phase_q;
        if (gate_rise)       phase_n = PH_ATTACK;
        else if (gate_fall)  phase_n = PH_RELEASE;
        else if (reach_full) phase_n = PH_DECAY;
    end

    always_comb begin
        hold_n = hold_q;
        if (gate_rise)                         hold_n = 1'b0;
        else if (step && level_n == LVL_ZERO)  hold_n = 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RELEASE;
            hold_q  <= 1'b1;
        end else begin
            phase_q <= phase_n;
            hold_q  <= hold_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= LVL_ZERO;
        else        level_q <= level_n;
    end

    assign level = level_q;
endmodule

// File: rtl/voice_envelope_chk.sv
module voice_envelope_chk
    import voice_env_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [LEVEL_W-1:0]  level,
    input env_phase_e          phase,
    input logic                hold,
    input logic                tick,
    input logic [EXPDIV_W-1:0] exp_period
);
    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level)) else $error("level moved without rate match"); // R2

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> (level == $past(level) + 8'd1) || (level == $past(level) - 8'd1))
        else $error("level jumped"); // R4

    AST_ATTACK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_ATTACK && level != $past(level)) |-> level == $past(level) + 8'd1)
        else $error("attack did not rise"); // R4

    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exp_period == 5'd1 || exp_period == 5'd2 || exp_period == 5'd4 ||
        exp_period == 5'd8 || exp_period == 5'd16 || exp_period == 5'd30)
        else $error("illegal divider period"); // R6

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(level)) else $error("frozen level moved"); // R10

    AST_FREEZE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> level == 8'h00) else $error("freeze away from zero"); // R10
endmodule

bind voice_envelope voice_envelope_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (level),
    .phase      (phase_q),
    .hold       (hold_q),
    .tick       (rate_tick),
    .exp_period (exp_period)
);

// File: tb/test_voice_envelope.sv
module test_voice_envelope;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0, ctrl_gate = 1'b0;
    logic       ad_we = 1'b0, sr_we = 1'b0;
    logic [7:0] ad_data = 8'h00, sr_data = 8'h00;
    logic [7:0] level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_rc;
    logic [4:0]  m_ec, m_ep;
    logic [7:0]  m_lvl;
    int          m_ph;     // 0 attack, 1 decay, 2 release
    logic        m_hz, m_gate;
    logic [3:0]  m_atk, m_dec, m_sus, m_rel;

    always #10 clk = ~clk;

    voice_envelope i_voice_envelope (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_gate(ctrl_gate),
        .ad_we(ad_we), .ad_data(ad_data),
        .sr_we(sr_we), .sr_data(sr_data),
        .level(level)
    );

    function automatic logic [15:0] ref_period(input logic [3:0] s);
        case (s)
            4'd0: return 16'd9;      4'd1: return 16'd32;
            4'd2: return 16'd63;     4'd3: return 16'd95;
            4'd4: return 16'd149;    4'd5: return 16'd220;
            4'd6: return 16'd267;    4'd7: return 16'd313;
            4'd8: return 16'd392;    4'd9: return 16'd977;
            4'd10: return 16'd1954;  4'd11: return 16'd3126;
            4'd12: return 16'd3907;  4'd13: return 16'd11720;
            4'd14: return 16'd19532; default: return 16'd31251;
        endcase
    endfunction

    function automatic logic [4:0] ref_reload(input logic [7:0] l, input logic [4:0] c);
        if (l == 8'hFF || l == 8'h00) return 5'd1;
        if (l == 8'h5D) return 5'd2;
        if (l == 8'h36) return 5'd4;
        if (l == 8'h1A) return 5'd8;
        if (l == 8'h0E) return 5'd16;
        if (l == 8'h06) return 5'd30;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rc = '0; m_ec = '0; m_ep = 5'd1; m_lvl = '0; m_ph = 2;
        m_hz = 1'b1; m_gate = 1'b0;
        m_atk = '0; m_dec = '0; m_sus = '0; m_rel = '0;
    endtask

    task automatic model_clock(input logic cwe, input logic cg, input logic awe,
                               input logic [7:0] ad, input logic swe, input logic [7:0] sr);
        logic [15:0] per, nx;
        logic tk, hit, to_dec;
        logic [7:0] nl;
        per = ref_period(m_ph == 0 ? m_atk : (m_ph == 1 ? m_dec : m_rel));
        nx = m_rc + 16'd1;
        tk = (nx == per);
        m_rc = tk ? 16'd0 : nx;
        to_dec = 1'b0;
        if (tk) begin
            hit = (m_ph == 0) || ((m_ec + 5'd1) == m_ep);
            m_ec = hit ? 5'd0 : m_ec + 5'd1;
            if (hit && !m_hz) begin
                nl = m_lvl;
                if (m_ph == 0) begin
                    nl = m_lvl + 8'd1;
                    to_dec = (nl == 8'hFF);
                end else if (m_ph == 1) begin
                    if (m_lvl != {m_sus, m_sus}) nl = m_lvl - 8'd1;
                end else begin
                    nl = m_lvl - 8'd1;
                end
                m_ep = ref_reload(nl, m_ep);
                if (nl == 8'h00) m_hz = 1'b1;
                m_lvl = nl;
            end
        end
        if (to_dec) m_ph = 1;
        if (cwe) begin
            if (cg && !m_gate) begin m_ph = 0; m_hz = 1'b0; end
            else if (!cg && m_gate) m_ph = 2;
            m_gate = cg;
        end
        if (awe) begin m_atk = ad[7:4]; m_dec = ad[3:0]; end
        if (swe) begin m_sus = sr[7:4]; m_rel = sr[3:0]; end
    endtask

    // One clock: drive at the falling edge, model after the rising edge, compare at the next falling edge.
    task automatic cyc(input logic cwe, input logic cg, input logic awe,
                       input logic [7:0] ad, input logic swe, input logic [7:0] sr);
        ctrl_we = cwe; ctrl_gate = cg; ad_we = awe; ad_data = ad; sr_we = swe; sr_data = sr;
        @(posedge clk);
        model_clock(cwe, cg, awe, ad, swe, sr);
        @(negedge clk);
        ctrl_we = 1'b0; ad_we = 1'b0; sr_we = 1'b0;
        check(level === m_lvl, "R2 level against model", int'(level), int'(m_lvl));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic wr_ctrl(input logic g); cyc(1'b1, g, 1'b0, 8'h00, 1'b0, 8'h00); endtask
    task automatic wr_ad(input logic [7:0] v); cyc(1'b0, 1'b0, 1'b1, v, 1'b0, 8'h00); endtask
    task automatic wr_sr(input logic [7:0] v); cyc(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, v); endtask

    task automatic to_change(output int n);
        logic [7:0] v;
        v = level; n = 0;
        do begin idle(1); n++; end while (level == v && n < 70000);
    endtask

    task automatic wait_level(input logic [7:0] t, input int maxc, input string req);
        int n;
        n = 0;
        while (level != t && n < maxc) begin idle(1); n++; end
        check(level == t, req, int'(level), int'(t));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, n2;
        void'($urandom(32'h0000_5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(level == 8'h00, "R1 reset level", int'(level), 0);
        idle(300);
        check(level == 8'h00, "R1 frozen at zero with gate low", int'(level), 0);

        // R8: attack 0, decay 0, sustain 5, release 0
        wr_sr(8'h50);
        wr_ad(8'h00);
        wr_ctrl(1'b1);
        idle(20);
        check(level != 8'h00, "R7 gate rise starts attack", int'(level), 1);
        to_change(n);
        to_change(n);
        check(n == 9, "R2 attack rate 0 interval", n, 9);
        wr_ad(8'h20);
        to_change(n);
        check(n + 1 == 63, "R9 new attack rate used at once", n + 1, 63);
        wr_ad(8'h00);
        wait_level(8'hFF, 3000, "R4 attack reaches full scale");
        wait_level(8'h55, 6000, "R5 decay reaches sustain 0x55");
        idle(3000);
        check(level == 8'h55, "R5 decay holds at sustain", int'(level), 8'h55);

        // R6: release through the divider steps
        wr_ctrl(1'b0);
        wait_level(8'h50, 500, "R7 gate fall starts release");
        to_change(n);
        check(n == 18, "R6 divider 2 below 0x5D", n, 18);
        wait_level(8'h30, 2000, "R6 reach 0x30");
        to_change(n);
        check(n == 36, "R6 divider 4 below 0x36", n, 36);
        wait_level(8'h18, 2000, "R6 reach 0x18");
        to_change(n);
        check(n == 72, "R6 divider 8 below 0x1A", n, 72);
        wait_level(8'h0C, 2000, "R6 reach 0x0C");
        to_change(n);
        check(n == 144, "R6 divider 16 below 0x0E", n, 144);
        wait_level(8'h05, 2000, "R6 reach 0x05");
        to_change(n);
        check(n == 270, "R6 divider 30 below 0x06", n, 270);
        wait_level(8'h00, 2000, "R10 release reaches zero");
        idle(1500);
        check(level == 8'h00, "R10 zero frozen", int'(level), 0);
        wr_ad(8'hFF);
        wr_sr(8'hF0);
        idle(500);
        check(level == 8'h00, "R10 rate writes ignored while frozen", int'(level), 0);

        // R3: a gate bounce does not restart the rate counter
        wr_ad(8'h30);
        wr_sr(8'h03);
        wr_ctrl(1'b1);
        to_change(n);
        to_change(n);
        check(n == 95, "R3 attack rate 3 interval", n, 95);
        idle(49);
        wr_ctrl(1'b0);
        wr_ctrl(1'b1);
        to_change(n2);
        check(49 + 2 + n2 == 95, "R3 step timing kept across gate bounce", 51 + n2, 95);

        // Random mix of writes checked against the model every cycle
        for (int i = 0; i < 80000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            if (r < 3) begin
                wr_ctrl(1'($urandom_range(0, 1)));
            end else if (r < 5) begin
                wr_ad({4'($urandom_range(0, 2)), 4'($urandom_range(0, 2))});
            end else if (r < 7) begin
                wr_sr({4'($urandom_range(0, 15)), 4'($urandom_range(0, 2))});
            end else begin
                idle(1);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule